// File: doc/BRIEF.md
# Multi-Mode Output Compare Channel

This block is one output-compare channel that watches a free-running timer count supplied from outside. It compares that count against two programmable values, a primary and a secondary, and drives a single output pin in one of eight ways. A 3-bit mode value selects the behaviour. The modes are off, a one-time rise, a one-time fall, a toggle on every match, a single pulse between the two values, a pulse that repeats every timer period, edge-aligned PWM and center-aligned PWM.

Software programs the channel through a small write port. A select field chooses which register the write data goes into. An external fault input pulls the pin to its safe low level while it is high. A one-cycle interrupt pulse marks every match that acts on the pin. The timer is outside the block and provides both the count and, for the center-aligned mode, its counting direction.

Top module: `occ_channel`

## Requirements
- R1: After reset the mode is off (000), and `pin_out` and `irq` are both low.
- R2: In mode 000 the pin stays low and `irq` never pulses.
- R3: In mode 001 the pin starts low. The first primary match drives it high. After that it stays high and no further match acts until the mode is written again.
- R4: In mode 010 the pin starts high. The first primary match drives it low. After that it stays low and no further match acts until the mode is written again.
- R5: In mode 011 every primary match inverts the pin.
- R6: In mode 100 the pin starts low. A primary match raises it, and a later secondary match lowers it. After that single pulse, no match acts until the mode is written again.
- R7: In mode 101 the pin starts low. While the pin is low, a primary match raises it. While the pin is high, a secondary match lowers it. This repeats in every timer period.
- R8: In mode 110 a count of zero raises the pin and a primary match lowers it. When both happen in the same cycle, the lowering wins, so a primary value of 0 gives 0% duty.
- R9: In mode 111 a primary match while `tmr_down` is low raises the pin. A primary match while `tmr_down` is high lowers it.
- R10: While `fault` is high in a cycle, the pin is low in the following cycle and `irq` does not pulse.
- R11: `irq` is high for exactly the cycle after each clock edge at which a match acted on the channel. It is never raised for a cycle in which the mode was written or `fault` was high.
- R12: A write with `wr_sel`=0 loads the mode from `wr_data[2:0]`, `wr_sel`=1 loads the primary value and `wr_sel`=2 loads the secondary value. `wr_sel`=3 is ignored. Every write takes effect at the next edge. A mode write, even of the current mode, re-arms the one-shot modes. It also sets the pin to the new mode's start level: high for 010, low for all others, and low when `fault` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_count | input | W | Current timer count |
| tmr_down | input | 1 | Timer counting down (used by center-aligned PWM) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 primary, 2 secondary |
| wr_data | input | W | Write data |
| fault | input | 1 | Fault input, forces the pin low |
| pin_out | output | 1 | Compare output pin |
| irq | output | 1 | One-cycle interrupt pulse on an acting match |

## Verification
The embedded assertions check the following on every cycle:
- the disabled mode keeps the pin low;
- a fault pulls the pin low and suppresses the interrupt;
- the continuous toggle mode always inverts the pin on a primary match;
- the one-shot modes never move the pin away from their final level;
- a mode write lands the pin on that mode's start level.

The bench's reference model runs beside the design and checks the rest. This covers the exact ordering of primary and secondary matches in the pulse modes and the PWM duty, including the zero-duty case. It also covers the up-then-down match pair of center-aligned PWM, re-arming after the mode is rewritten, and recovery once a fault is released.

// File: rtl/occ_channel.sv
module occ_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tmr_count,
  input  logic         tmr_down,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         fault,
  output logic         pin_out,
  output logic         irq
);

  localparam logic [2:0] M_OFF   = 3'd0;
  localparam logic [2:0] M_RISE  = 3'd1;
  localparam logic [2:0] M_FALL  = 3'd2;
  localparam logic [2:0] M_TOG   = 3'd3;
  localparam logic [2:0] M_PULSE = 3'd4;
  localparam logic [2:0] M_TRAIN = 3'd5;
  localparam logic [2:0] M_EPWM  = 3'd6;
  localparam logic [2:0] M_CPWM  = 3'd7;

  logic [2:0]   mode_q;
  logic [W-1:0] pri_q, sec_q;
  logic         done_q;
  logic         pin_d, done_d, irq_d;

  wire hit_p   = tmr_count == pri_q;
  wire hit_s   = tmr_count == sec_q;
  wire mode_wr = wr_en && wr_sel == 2'd0;

  always_comb begin
    pin_d  = pin_out;
    done_d = done_q;
    irq_d  = 1'b0;
    case (mode_q)
      M_RISE, M_FALL: if (!done_q && hit_p) begin
        pin_d = (mode_q == M_RISE);
        done_d = 1'b1;
        irq_d = 1'b1;
      end
      M_TOG: if (hit_p) begin
        pin_d = !pin_out;
        irq_d = 1'b1;
      end
      M_PULSE, M_TRAIN: if (!done_q) begin
        if (!pin_out && hit_p) begin
          pin_d = 1'b1;
          irq_d = 1'b1;
        end else if (pin_out && hit_s) begin
          pin_d = 1'b0;
          done_d = (mode_q == M_PULSE);
          irq_d = 1'b1;
        end
      end
      M_EPWM: begin
        if (tmr_count == '0) pin_d = 1'b1;
        if (hit_p) begin
          pin_d = 1'b0;
          irq_d = 1'b1;
        end
      end
      M_CPWM: if (hit_p) begin
        pin_d = !tmr_down;
        irq_d = 1'b1;
      end
      default: pin_d = 1'b0;
    endcase
    if (fault) begin
      pin_d = 1'b0;
      irq_d = 1'b0;
    end
    if (mode_wr) begin
      pin_d  = (wr_data[2:0] == M_FALL) && !fault;
      done_d = 1'b0;
      irq_d  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= M_OFF;
      pri_q   <= '0;
      sec_q   <= '0;
      done_q  <= 1'b0;
      pin_out <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= wr_data[2:0];
      if (wr_en && wr_sel == 2'd1) pri_q <= wr_data;
      if (wr_en && wr_sel == 2'd2) sec_q <= wr_data;
      done_q  <= done_d;
      pin_out <= pin_d;
      irq     <= irq_d;
    end
  end

  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF && !mode_wr) |=> (!pin_out && !irq));

  a_r10_fault_safe: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!pin_out && !irq));

  a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TOG && hit_p && !fault && !mode_wr) |=> (pin_out != $past(pin_out)));

  a_r3_rise_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RISE && pin_out && !fault && !mode_wr) |=> pin_out);

  a_r4_fall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FALL && !pin_out && !fault && !mode_wr) |=> !pin_out);

  a_r12_start_level: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !fault) |=> (pin_out == ($past(wr_data[2:0]) == M_FALL)));

endmodule

// File: tb/occ_channel_bench.sv
module occ_channel_bench;
  localparam int W = 8;
  localparam int PER = 20;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] tmr_count = 0;
  logic tmr_down = 0, wr_en = 0, fault = 0;
  logic [1:0] wr_sel = 0;
  logic [W-1:0] wr_data = 0;
  logic pin_out, irq;

  int checks = 0, errors = 0;
  bit run_tmr = 0, updown = 0;

  // reference state
  int m_mode = 0, m_a = 0, m_b = 0;
  bit m_pin = 0, m_irq = 0, m_armed = 1;
  bit last_fault = 0, last_wr = 0;

  occ_channel #(.W(W)) u_occ_channel (.*);

  always #5 clk = ~clk;

  function automatic string mode_tag(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    int t;
    bit np, ni;
    t = tmr_count;
    last_fault = fault;
    last_wr = wr_en && wr_sel == 0;
    if (!rst_n) begin
      m_mode = 0; m_a = 0; m_b = 0; m_pin = 0; m_irq = 0; m_armed = 1;
    end else begin
      np = m_pin; ni = 0;
      if (m_mode == 1 && m_armed && t == m_a) begin np = 1; ni = 1; m_armed = 0; end
      if (m_mode == 2 && m_armed && t == m_a) begin np = 0; ni = 1; m_armed = 0; end
      if (m_mode == 3 && t == m_a) begin np = !m_pin; ni = 1; end
      if ((m_mode == 4 && m_armed) || m_mode == 5) begin
        if (m_pin == 0 && t == m_a) begin np = 1; ni = 1; end
        else if (m_pin == 1 && t == m_b) begin
          np = 0; ni = 1;
          if (m_mode == 4) m_armed = 0;
        end
      end
      if (m_mode == 6) begin
        if (t == m_a) begin np = 0; ni = 1; end
        else if (t == 0) np = 1;
      end
      if (m_mode == 7 && t == m_a) begin np = tmr_down ? 0 : 1; ni = 1; end
      if (m_mode == 0) np = 0;
      if (fault) begin np = 0; ni = 0; end
      if (wr_en) begin
        if (wr_sel == 0) begin
          m_mode = wr_data[2:0]; m_armed = 1; ni = 0;
          np = (m_mode == 2) && !fault;
        end else if (wr_sel == 1) m_a = wr_data;
        else if (wr_sel == 2) m_b = wr_data;
      end
      m_pin = np; m_irq = ni;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      checks++;
      if (pin_out !== m_pin) begin
        errors++;
        $display("FAIL %s pin_out actual %0b expected %0b at t=%0d",
                 last_fault ? "R10" : (last_wr ? "R12" : mode_tag(m_mode)),
                 pin_out, m_pin, tmr_count);
      end
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R11 irq actual %0b expected %0b mode %0d", irq, m_irq, m_mode);
      end
    end
  end

  always @(negedge clk) begin
    if (run_tmr) begin
      if (!updown) tmr_count <= (tmr_count == PER - 1) ? 0 : tmr_count + 1;
      else if (!tmr_down) begin
        if (tmr_count == PER) begin tmr_down <= 1; tmr_count <= tmr_count - 1; end
        else tmr_count <= tmr_count + 1;
      end else begin
        if (tmr_count == 0) begin tmr_down <= 0; tmr_count <= 1; end
        else tmr_count <= tmr_count - 1;
      end
    end
  end

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    wr_en = 1; wr_sel = sel[1:0]; wr_data = val[W-1:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #2;
    checks++;
    if (pin_out !== 0 || irq !== 0) begin
      errors++;
      $display("FAIL R1 reset pin/irq actual %0b%0b expected 00", pin_out, irq);
    end
    run_tmr = 1;
    idle(25);                          // R2 disabled
    wr(1, 5); wr(2, 12); wr(3, 99);    // R12 sel 3 ignored
    for (int m = 1; m <= 6; m++) begin // R3..R8
      wr(0, m);
      idle(50);
    end
    wr(0, 1); idle(30); wr(0, 1); idle(30);  // R12 re-arm same mode
    wr(0, 4); idle(10); fault = 1; idle(4); fault = 0; idle(40); // R10 mid-pulse
    wr(0, 6); wr(1, 0); idle(45);      // R8 zero duty
    wr(1, 7); idle(25);
    fault = 1; wr(0, 2); idle(3); fault = 0; idle(25); // R10 with mode write
    wr(0, 3); wr(1, 12); idle(30);     // R5 toggle
    @(negedge clk); updown = 1; tmr_count = 0; tmr_down = 0;
    wr(1, 6); wr(0, 7); idle(90);      // R9 center PWM
    wr(0, 0); idle(20);                // R2
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule